// File: doc/BRIEF.md
# Multiplexed-Bus External SRAM Controller

This block lets a small 8-bit CPU reach an external asynchronous SRAM through a narrow pin set. One 8-bit bidirectional port carries two things in turn: first the low address byte, then the data byte. A separate 8-bit port carries the high address byte. An external transparent latch, open while `ale` is high, holds the low address byte once `ale` falls. The block drives active-low read and write strobes, `rd_n` and `wr_n`. The CPU uses a request/ready handshake. It keeps `req_valid` and the request fields steady until it sees `req_ready` high in the data cycle. From the next cycle it may present another request or drop `req_valid`.

A two-bit configuration register is loaded through `cfg_we`. The enable bit switches both ports from plain general-purpose outputs, driven by `gpio_*_out` and `gpio_*_dir`, to bus mode. In bus mode the port direction settings are overridden. The wait bit adds one wait cycle, before the data cycle, to each access that starts after it is set. Addresses below the parameter `INT_TOP` belong to internal memory. For those addresses the block raises no `ale`, no strobe and no ready.

The sequencer has four states:
- `ST_IDLE`: the address cycle when a request is accepted.
- `ST_LATCH`: `ale` is low and the address is held.
- `ST_WAIT`: the optional wait cycle.
- `ST_XFER`: the single data cycle.

Its transitions are:
- IDLE→LATCH on an accepted external request.
- LATCH→WAIT when the wait bit was captured set.
- LATCH→XFER when it was captured clear.
- WAIT→XFER always.
- XFER→IDLE always.

Top module: `xmem_mux_ctrl`

## Requirements
- R1: After reset `rd_n` and `wr_n` are 1, `ale` is 0 and `req_ready` is 0. Both configuration bits are cleared, so `pad_ad_o`/`pad_ad_oe` equal `gpio_lo_out`/`gpio_lo_dir` and `pad_hi_o`/`pad_hi_oe` equal `gpio_hi_out`/`gpio_hi_dir`.
- R2: A cycle with `cfg_we` high loads `cfg_ext_en_d` into the enable bit and `cfg_wait_d` into the wait bit. With the enable bit set, both output enables read all ones outside a read data cycle.
- R3: With the enable bit clear, the pins follow the general-purpose inputs. A request to any address raises no `ale`, no strobe and no `req_ready`.
- R4: With the enable bit set, a request with `req_addr` below `INT_TOP` raises no `ale`, no strobe and no `req_ready`.
- R5: In the cycle an external request is accepted, `ale` is 1, `pad_ad_o` = `req_addr[7:0]` and `pad_hi_o` = `req_addr[15:8]`. In the following cycle `ale` is 0, the shared port still drives the low address byte, and both strobes are 1.
- R6: Counting the accept cycle and the ready cycle, an access lasts 3 cycles when the wait bit was clear at acceptance and 4 cycles when it was set. `req_ready` is 1 only in the last of these cycles.
- R7: In the data cycle of a write, `wr_n` is 0 for exactly one cycle, `pad_ad_o` carries the write data and `pad_ad_oe` is all ones.
- R8: In the data cycle of a read, `rd_n` is 0 for exactly one cycle and `pad_ad_oe` is all zeros. The value on `pad_ad_i` at the end of that cycle appears on `rsp_rdata` from the next cycle.
- R9: In the cycle after the data cycle, with no new request, the shared port again drives the low address byte of the finished access, with `pad_ad_oe` all ones.
- R10: No turnaround is inserted. A request present in the cycle after `req_ready` is accepted at once (`ale` is 1 in that cycle), whether the direction changes from write to read or from read to write.
- R11: `pad_ad_oe` is never nonzero while `rd_n` is 0, and `rd_n` and `wr_n` are never 0 together.
- R12: During an access, `pad_hi_o` holds the high address byte from acceptance through the data cycle, with `pad_hi_oe` all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the configuration bits |
| cfg_ext_en_d | input | 1 | New value of the bus-mode enable bit |
| cfg_wait_d | input | 1 | New value of the wait-state bit |
| req_valid | input | 1 | CPU request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | External access completes this cycle |
| rsp_rdata | output | 8 | Last captured read data |
| gpio_lo_out | input | 8 | Shared port value in general-purpose mode |
| gpio_lo_dir | input | 8 | Shared port output enables in general-purpose mode |
| gpio_hi_out | input | 8 | High port value in general-purpose mode |
| gpio_hi_dir | input | 8 | High port output enables in general-purpose mode |
| pad_ad_o | output | 8 | Shared address/data port output value |
| pad_ad_oe | output | 8 | Shared port output enables |
| pad_ad_i | input | 8 | Shared port input value |
| pad_hi_o | output | 8 | High address port value |
| pad_hi_oe | output | 8 | High address port output enables |
| ale | output | 1 | Address latch enable, latch transparent while high |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
The bound checker enforces the pin-level safety rules on every cycle:
- the shared port is never driven during a read strobe;
- the two strobes never overlap;
- every strobe and every `ale` pulse lasts one cycle;
- the high address byte is steady while a strobe is low;
- `ale` only rises for an external address.

Only the bench scenarios can show the remaining behaviour, because each of these needs an external latch and memory model or a count of cycles across a whole transaction:
- access length with and without the wait bit;
- data written and then read back through the latch model;
- the shared port returning to the address after the data cycle;
- back-to-back accesses in opposite directions with no gap;
- general-purpose pass-through while the enable bit is clear.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    // Bus sequencer phases
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // idle, doubles as address cycle on acceptance
        ST_LATCH = 2'd1,   // ale low, address held for the latch
        ST_WAIT  = 2'd2,   // optional stretch cycle
        ST_XFER  = 2'd3    // single data cycle with strobe
    } xmem_state_t;

endpackage

// File: rtl/xmem_cfg_reg.sv
module xmem_cfg_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic cfg_ext_en_d,
    input  logic cfg_wait_d,
    output logic ext_en,
    output logic wait_en
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_en  <= 1'b0;
            wait_en <= 1'b0;
        end else if (cfg_we) begin
            ext_en  <= cfg_ext_en_d;
            wait_en <= cfg_wait_d;
        end
    end

endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter int                DATA_W  = 8,
    parameter logic [ADDR_W-1:0] INT_TOP = 16'h1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_en,
    input  logic              wait_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] pad_in,
    output logic              ale,
    output logic              busy,
    output logic              req_ready,
    output logic              rd_act,
    output logic              wr_act,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    xmem_state_t state, state_nx;
    logic        write_q;
    logic        wait_q;
    logic        hit;

    // an external request: bus mode on and address at or above the internal top
    assign hit = req_valid && ext_en && (req_addr >= INT_TOP);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (hit) state_nx = ST_LATCH;
            ST_LATCH: state_nx = wait_q ? ST_WAIT : ST_XFER;
            ST_WAIT:  state_nx = ST_XFER;
            ST_XFER:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // request capture and read-data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
            wait_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (state == ST_IDLE && hit) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                write_q <= req_write;
                wait_q  <= wait_en;
            end
            if (state == ST_XFER && !write_q) begin
                rdata_q <= pad_in;
            end
        end
    end

    // phase outputs
    always_comb begin
        ale       = 1'b0;
        busy      = 1'b1;
        req_ready = 1'b0;
        rd_act    = 1'b0;
        wr_act    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                ale  = hit;
            end
            ST_LATCH, ST_WAIT: begin
            end
            ST_XFER: begin
                req_ready = 1'b1;
                rd_act    = !write_q;
                wr_act    = write_q;
            end
        endcase
    end

endmodule

// File: rtl/xmem_pin_mux.sv
module xmem_pin_mux #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     bus_mode,
    input  logic                     ale,
    input  logic                     rd_act,
    input  logic                     wr_act,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [ADDR_W-1:0]        addr_q,
    input  logic [DATA_W-1:0]        wdata_q,
    input  logic [DATA_W-1:0]        gpio_lo_out,
    input  logic [DATA_W-1:0]        gpio_lo_dir,
    input  logic [ADDR_W-DATA_W-1:0] gpio_hi_out,
    input  logic [ADDR_W-DATA_W-1:0] gpio_hi_dir,
    output logic [DATA_W-1:0]        pad_ad_o,
    output logic [DATA_W-1:0]        pad_ad_oe,
    output logic [ADDR_W-DATA_W-1:0] pad_hi_o,
    output logic [ADDR_W-DATA_W-1:0] pad_hi_oe,
    output logic                     rd_n,
    output logic                     wr_n
);

    localparam int HI_W = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] addr_cur;

    // during acceptance the address comes straight from the request
    assign addr_cur = ale ? req_addr : addr_q;

    always_comb begin
        if (bus_mode) begin
            pad_ad_o  = wr_act ? wdata_q : addr_cur[DATA_W-1:0];
            pad_ad_oe = rd_act ? '0 : '1;
            pad_hi_o  = addr_cur[ADDR_W-1:DATA_W];
            pad_hi_oe = {HI_W{1'b1}};
        end else begin
            pad_ad_o  = gpio_lo_out;
            pad_ad_oe = gpio_lo_dir;
            pad_hi_o  = gpio_hi_out;
            pad_hi_oe = gpio_hi_dir;
        end
        rd_n = !rd_act;
        wr_n = !wr_act;
    end

endmodule

// File: rtl/xmem_mux_ctrl.sv
module xmem_mux_ctrl #(
    parameter int                ADDR_W  = 16,
    parameter int                DATA_W  = 8,
    parameter logic [ADDR_W-1:0] INT_TOP = 16'h1000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic                     cfg_ext_en_d,
    input  logic                     cfg_wait_d,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_ready,
    output logic [DATA_W-1:0]        rsp_rdata,
    input  logic [DATA_W-1:0]        gpio_lo_out,
    input  logic [DATA_W-1:0]        gpio_lo_dir,
    input  logic [ADDR_W-DATA_W-1:0] gpio_hi_out,
    input  logic [ADDR_W-DATA_W-1:0] gpio_hi_dir,
    output logic [DATA_W-1:0]        pad_ad_o,
    output logic [DATA_W-1:0]        pad_ad_oe,
    input  logic [DATA_W-1:0]        pad_ad_i,
    output logic [ADDR_W-DATA_W-1:0] pad_hi_o,
    output logic [ADDR_W-DATA_W-1:0] pad_hi_oe,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n
);

    logic              ext_en, wait_en;
    logic              busy, rd_act, wr_act;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    xmem_cfg_reg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_ext_en_d (cfg_ext_en_d),
        .cfg_wait_d   (cfg_wait_d),
        .ext_en       (ext_en),
        .wait_en      (wait_en)
    );

    xmem_seq #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .INT_TOP (INT_TOP)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_en    (ext_en),
        .wait_en   (wait_en),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .pad_in    (pad_ad_i),
        .ale       (ale),
        .busy      (busy),
        .req_ready (req_ready),
        .rd_act    (rd_act),
        .wr_act    (wr_act),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .rdata_q   (rsp_rdata)
    );

    // an access in flight keeps the bus even if the enable bit drops
    xmem_pin_mux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .bus_mode    (ext_en || busy),
        .ale         (ale),
        .rd_act      (rd_act),
        .wr_act      (wr_act),
        .req_addr    (req_addr),
        .addr_q      (addr_q),
        .wdata_q     (wdata_q),
        .gpio_lo_out (gpio_lo_out),
        .gpio_lo_dir (gpio_lo_dir),
        .gpio_hi_out (gpio_hi_out),
        .gpio_hi_dir (gpio_hi_dir),
        .pad_ad_o    (pad_ad_o),
        .pad_ad_oe   (pad_ad_oe),
        .pad_hi_o    (pad_hi_o),
        .pad_hi_oe   (pad_hi_oe),
        .rd_n        (rd_n),
        .wr_n        (wr_n)
    );

endmodule

// File: rtl/xmem_mux_ctrl_chk.sv
module xmem_mux_ctrl_chk #(
    parameter int                ADDR_W  = 16,
    parameter int                DATA_W  = 8,
    parameter logic [ADDR_W-1:0] INT_TOP = 16'h1000
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic [ADDR_W-1:0]        req_addr,
    input logic                     req_ready,
    input logic [DATA_W-1:0]        pad_ad_oe,
    input logic [ADDR_W-DATA_W-1:0] pad_hi_o,
    input logic                     ale,
    input logic                     rd_n,
    input logic                     wr_n
);

    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    p_rd_no_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (pad_ad_oe == '0));

    p_wr_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (pad_ad_oe == '1));

    p_wr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |=> wr_n);

    p_rd_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |=> rd_n);

    p_ale_then_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!ale && rd_n && wr_n));

    p_ale_external_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (req_valid && req_addr >= INT_TOP));

    p_ready_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (rd_n != wr_n));

    p_hi_steady_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> $stable(pad_hi_o));

endmodule

bind xmem_mux_ctrl xmem_mux_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .INT_TOP (INT_TOP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .pad_ad_oe (pad_ad_oe),
    .pad_hi_o  (pad_hi_o),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n)
);

// File: tb/xmem_mux_ctrl_bench.sv
module xmem_mux_ctrl_bench;

    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we, cfg_ext_en_d, cfg_wait_d;
    logic        req_valid, req_write;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        req_ready;
    logic [7:0]  rsp_rdata;
    logic [7:0]  gpio_lo_out, gpio_lo_dir, gpio_hi_out, gpio_hi_dir;
    logic [7:0]  pad_ad_o, pad_ad_oe, pad_ad_i, pad_hi_o, pad_hi_oe;
    logic        ale, rd_n, wr_n;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_NS/2) clk = ~clk;

    xmem_mux_ctrl u_xmem_mux_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_ext_en_d(cfg_ext_en_d), .cfg_wait_d(cfg_wait_d),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
        .gpio_lo_out(gpio_lo_out), .gpio_lo_dir(gpio_lo_dir),
        .gpio_hi_out(gpio_hi_out), .gpio_hi_dir(gpio_hi_dir),
        .pad_ad_o(pad_ad_o), .pad_ad_oe(pad_ad_oe), .pad_ad_i(pad_ad_i),
        .pad_hi_o(pad_hi_o), .pad_hi_oe(pad_hi_oe),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
    );

    // external latch plus small SRAM model
    logic [7:0] lat_lo;
    logic [7:0] mem [0:1023];
    always_latch if (ale) lat_lo = pad_ad_o;
    assign pad_ad_i = !rd_n ? mem[{pad_hi_o[1:0], lat_lo}] : 8'h5A;
    always @(negedge clk) if (!wr_n) mem[{pad_hi_o[1:0], lat_lo}] <= pad_ad_o;

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic en, input logic wt);
        cfg_we = 1'b1; cfg_ext_en_d = en; cfg_wait_d = wt;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // starts just after a falling edge; returns one cycle after the data cycle
    task automatic run_access(input logic w, input logic [15:0] a, input logic [7:0] d, input logic wt);
        int n;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = w ? d : 8'h00;
        #1;
        check(ale && pad_ad_o == a[7:0] && pad_hi_o == a[15:8], "R5 accept",
              {ale, pad_hi_o, pad_ad_o}, {1'b1, a});
        @(negedge clk); n = 2;
        check(!ale && pad_ad_o == a[7:0] && rd_n && wr_n, "R5 hold",
              {ale, rd_n, wr_n, pad_ad_o}, {3'b011, a[7:0]});
        while (!req_ready && n < 10) begin @(negedge clk); n++; end
        check(n == (wt ? 4 : 3), "R6 length", n, wt ? 4 : 3);
        if (w) check(!wr_n && rd_n && pad_ad_o == d && pad_ad_oe == 8'hFF, "R7 write cycle",
                     {wr_n, rd_n, pad_ad_oe, pad_ad_o}, {2'b01, 8'hFF, d});
        else   check(!rd_n && wr_n && pad_ad_oe == 8'h00, "R8 R11 read cycle",
                     {rd_n, wr_n, pad_ad_oe}, {2'b01, 8'h00});
        check(pad_hi_o == a[15:8] && pad_hi_oe == 8'hFF, "R12 high byte",
              {pad_hi_oe, pad_hi_o}, {8'hFF, a[15:8]});
        req_valid = 1'b0;
        @(negedge clk);
        check(rd_n && wr_n && !ale && pad_ad_o == a[7:0] && pad_ad_oe == 8'hFF, "R9 address back",
              {rd_n, wr_n, ale, pad_ad_oe, pad_ad_o}, {3'b110, 8'hFF, a[7:0]});
        if (!w) check(rsp_rdata == d, "R8 read data", rsp_rdata, d);
    endtask

    typedef struct packed {
        logic        wr;
        logic        wt;
        logic [15:0] addr;
        logic [7:0]  data;   // write data or expected read data
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 1'b0, 16'h1000, 8'hA5},
        '{1'b1, 1'b1, 16'h12FF, 8'h3C},
        '{1'b0, 1'b0, 16'h1000, 8'hA5},
        '{1'b0, 1'b1, 16'h12FF, 8'h3C},
        '{1'b1, 1'b1, 16'hFFFF, 8'h81},
        '{1'b0, 1'b0, 16'hFFFF, 8'h81},
        '{1'b1, 1'b0, 16'h1234, 8'h5E},
        '{1'b0, 1'b1, 16'h1234, 8'h5E}
    };

    initial begin
        #(CLK_NS * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_ext_en_d = 1'b0; cfg_wait_d = 1'b0;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        gpio_lo_out = 8'h33; gpio_lo_dir = 8'h0F; gpio_hi_out = 8'h44; gpio_hi_dir = 8'hF0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(rd_n && wr_n && !ale && !req_ready, "R1 strobes", {rd_n, wr_n, ale, req_ready}, 4'b1100);
        check(pad_ad_o == 8'h33 && pad_ad_oe == 8'h0F && pad_hi_o == 8'h44 && pad_hi_oe == 8'hF0,
              "R1 gpio", {pad_ad_o, pad_ad_oe, pad_hi_o, pad_hi_oe}, 32'h330F44F0);

        // R3 disabled: external address request ignored
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h2000;
        for (int i = 0; i < 4; i++) begin
            #1;
            check(!ale && rd_n && wr_n && !req_ready && pad_ad_oe == 8'h0F && pad_hi_o == 8'h44,
                  "R3 disabled", {ale, rd_n, wr_n, req_ready, pad_ad_oe}, {4'b0110, 8'h0F});
            @(negedge clk);
        end
        req_valid = 1'b0;

        // R2 enable switches port ownership
        set_cfg(1'b1, 1'b0);
        check(pad_ad_oe == 8'hFF && pad_hi_oe == 8'hFF, "R2 bus mode", {pad_ad_oe, pad_hi_oe}, 16'hFFFF);

        // R4 internal address (just below boundary)
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0FFF; req_wdata = 8'hEE;
        for (int i = 0; i < 4; i++) begin
            #1;
            check(!ale && rd_n && wr_n && !req_ready, "R4 internal",
                  {ale, rd_n, wr_n, req_ready}, 4'b0110);
            @(negedge clk);
        end
        req_valid = 1'b0;

        // table walk
        for (int v = 0; v < 8; v++) begin
            set_cfg(1'b1, VECS[v].wt);
            run_access(VECS[v].wr, VECS[v].addr, VECS[v].data, VECS[v].wt);
        end

        // R10 back-to-back, write then read then write, no gap
        set_cfg(1'b1, 1'b0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h1100; req_wdata = 8'h77;
        while (!req_ready) @(negedge clk);
        req_write = 1'b0; req_addr = 16'h1100;
        @(negedge clk);
        check(ale && pad_ad_o == 8'h00, "R10 write->read", {ale, pad_ad_o}, 9'h100);
        while (!req_ready) @(negedge clk);
        req_write = 1'b1; req_addr = 16'h1101; req_wdata = 8'h99;
        @(negedge clk);
        check(ale && pad_ad_o == 8'h01, "R10 read->write", {ale, pad_ad_o}, 9'h101);
        check(rsp_rdata == 8'h77, "R8 back-to-back data", rsp_rdata, 8'h77);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        run_access(1'b0, 16'h1101, 8'h99, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule